// File: doc/BRIEF.md
# Repeating Block Memory Copy Engine

This block moves a run of bytes from one region of a byte-addressed memory to another. The caller gives it three things: a source pointer, a destination pointer and a byte count. It also gives a direction bit and the current processor flag byte, and then pulses `start`. For each byte the engine reads the source location, writes that byte to the destination location on the next cycle, steps both pointers by one in the chosen direction and decrements the count. It repeats until the count reaches zero. Then it clears three of the flags, pulses `done` for one cycle and keeps the final pointer, count, flag and cost values on its outputs until the next start.

The engine also adds up the cost that the repeating instruction it models would report. Each repeating step adds five machine cycles and twenty-one clock states. The last step adds four machine cycles and sixteen states. A count of zero at start is not an empty copy: the first decrement wraps it to the top of its range, so a full 65536 bytes move.

The memory port is a plain synchronous single-port request interface. `mem_req` with `mem_we` low is a read, and its data must be on `mem_rdata` in the next cycle. `mem_req` with `mem_we` high is a write in that same cycle. The memory cannot stall the engine: there is no back-pressure, and every request is assumed accepted in the cycle it is raised.

Top module: `blkcopy_engine`

## Requirements
- R1: Each byte takes one read cycle at the source pointer followed directly by one write cycle at the destination pointer, carrying the byte read. Bytes move strictly one after another, so overlapping regions behave like a sequential byte loop.
- R2: With `dir_down` = 0 both pointers increase by 1 after every byte; with `dir_down` = 1 both decrease by 1.
- R3: The count decreases by 1 after every byte, and the engine stops after the step that brings it to zero, leaving `cnt_out` = 0.
- R4: A start count of 0 copies 65536 bytes. Pointers and count all wrap modulo 2^16.
- R5: The flag byte uses bit positions S=7, Z=6, H=4, P/V=2, N=1, C=0. At completion H, P/V and N are 0, and every other bit equals the `flags_in` value captured at start.
- R6: The cost totals clear at start. Each non-final step adds 5 to `mcyc_total` and 21 to `tst_total`, and the final step adds 4 and 16.
- R7: A `start` pulse while `busy` is high has no effect on the copy in progress or its results.
- R8: `done` is high for exactly one cycle, the cycle after the final write. All result outputs hold their values until the next accepted start.
- R9: After reset, `busy`, `done` and `mem_req` are 0, and the pointers, count, flags and totals read 0.
- R10: `mem_req` is raised only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a copy; taken only when idle |
| dir_down | input | 1 | 0 = pointers count up, 1 = count down |
| src_init | input | 16 | Starting source pointer |
| dst_init | input | 16 | Starting destination pointer |
| cnt_init | input | 16 | Starting byte count (0 means 65536) |
| flags_in | input | 8 | Flag byte captured at start |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after the read |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| cnt_out | output | 16 | Current remaining count |
| flags_out | output | 8 | Flag byte |
| mcyc_total | output | 20 | Accumulated machine cycles |
| tst_total | output | 24 | Accumulated clock states |

## Verification
The hardest situation to reach is the zero-count start. Only a full 65536-byte pass exposes it, and that pass ends with both pointers wrapped all the way around to their starting values. The stimulus runs one complete pass of this kind. It counts writes at the memory model and checks the totals against the closed form for 65536 steps. A second hard case is a start pulse that lands mid-copy. The bench aims one, with different operands, at the second cycle of a multi-byte copy and confirms that the results still match the first request. Overlapping source and destination ranges are also driven, and the memory image is compared with a sequential reference loop.

// File: rtl/bcopy_pkg.sv
package bcopy_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} bc_state_t;

  localparam int FL_C  = 0;
  localparam int FL_N  = 1;
  localparam int FL_PV = 2;
  localparam int FL_H  = 4;
  localparam int FL_Z  = 6;
  localparam int FL_S  = 7;
  localparam logic [7:0] FL_KEEP_MASK =
    ~((8'd1 << FL_N) | (8'd1 << FL_PV) | (8'd1 << FL_H));

  localparam int MC_REPEAT = 5;
  localparam int MC_FINAL  = 4;
  localparam int TS_REPEAT = 21;
  localparam int TS_FINAL  = 16;
endpackage

// File: rtl/bcopy_ptr.sv
module bcopy_ptr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         down,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (step)  q <= down ? q - W'(1) : q + W'(1);
  end
endmodule

// File: rtl/bcopy_cost.sv
module bcopy_cost
  import bcopy_pkg::*;
#(
  parameter int MW = 20,
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add,
  input  logic          final_step,
  output logic [MW-1:0] mc,
  output logic [TW-1:0] ts
);
  logic [MW-1:0] mc_inc;
  logic [TW-1:0] ts_inc;

  always_comb begin
    mc_inc = final_step ? MW'(MC_FINAL) : MW'(MC_REPEAT);
    ts_inc = final_step ? TW'(TS_FINAL) : TW'(TS_REPEAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc <= '0;
      ts <= '0;
    end else if (clr) begin
      mc <= '0;
      ts <= '0;
    end else if (add) begin
      mc <= mc + mc_inc;
      ts <= ts + ts_inc;
    end
  end
endmodule

// File: rtl/bcopy_ctrl.sv
module bcopy_ctrl
  import bcopy_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic last,
  output logic load,
  output logic rd_phase,
  output logic wr_phase,
  output logic busy,
  output logic done
);
  bc_state_t st_q, st_d;

  always_comb begin
    load     = start && (st_q == ST_IDLE);
    rd_phase = (st_q == ST_RD);
    wr_phase = (st_q == ST_WR);
    busy     = (st_q != ST_IDLE);
    st_d     = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_RD;
      ST_RD:   st_d = ST_WR;
      ST_WR:   st_d = last ? ST_IDLE : ST_RD;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= wr_phase && last;
    end
  end
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
  import bcopy_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8,
  parameter int MW = 20,
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_down,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] dst_init,
  input  logic [CW-1:0] cnt_init,
  input  logic [7:0]    flags_in,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] cnt_out,
  output logic [7:0]    flags_out,
  output logic [MW-1:0] mcyc_total,
  output logic [TW-1:0] tst_total
);
  localparam int NPTR = 2;

  logic load, rd_phase, wr_phase, last;
  logic dir_q;
  logic [AW-1:0] ptr_init [NPTR];
  logic [AW-1:0] ptr_q    [NPTR];

  assign ptr_init[0] = src_init;
  assign ptr_init[1] = dst_init;
  assign src_ptr     = ptr_q[0];
  assign dst_ptr     = ptr_q[1];

  bcopy_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .last(last),
    .load(load), .rd_phase(rd_phase), .wr_phase(wr_phase),
    .busy(busy), .done(done)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    bcopy_ptr #(.W(AW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(ptr_init[g]),
      .step(wr_phase), .down(dir_q), .q(ptr_q[g])
    );
  end

  // count only ever steps down; a zero start wraps on the first step
  bcopy_ptr #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(cnt_init),
    .step(wr_phase), .down(1'b1), .q(cnt_out)
  );
  assign last = (cnt_out == CW'(1));

  bcopy_cost #(.MW(MW), .TW(TW)) u_cost (
    .clk(clk), .rst_n(rst_n), .clr(load), .add(wr_phase),
    .final_step(last), .mc(mcyc_total), .ts(tst_total)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= 1'b0;
      flags_out <= '0;
    end else if (load) begin
      dir_q     <= dir_down;
      flags_out <= flags_in;
    end else if (wr_phase && last) begin
      flags_out <= flags_out & FL_KEEP_MASK;
    end
  end

  always_comb begin
    mem_req   = rd_phase || wr_phase;
    mem_we    = wr_phase;
    mem_addr  = wr_phase ? ptr_q[1] : ptr_q[0];
    mem_wdata = mem_rdata;
  end
endmodule

// File: rtl/blkcopy_checker.sv
module blkcopy_checker
  import bcopy_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int TW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          dir_q,
  input logic          mem_req,
  input logic          mem_we,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] src_ptr,
  input logic [AW-1:0] dst_ptr,
  input logic [CW-1:0] cnt_out,
  input logic [7:0]    flags_out,
  input logic [TW-1:0] tst_total
);
  a_r1_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $past(mem_req && !mem_we));

  a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !dir_q) |=>
      (src_ptr == AW'($past(src_ptr) + AW'(1))) && (dst_ptr == AW'($past(dst_ptr) + AW'(1))));

  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && dir_q) |=>
      (src_ptr == AW'($past(src_ptr) - AW'(1))) && (dst_ptr == AW'($past(dst_ptr) - AW'(1))));

  a_r3_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt_out == '0));

  a_r5_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((flags_out & ~FL_KEEP_MASK) == 8'h00));

  a_r6_cost_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=>
      (tst_total == TW'($past(tst_total) + ((cnt_out == '0) ? TW'(TS_FINAL) : TW'(TS_REPEAT)))));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=>
      ($stable(src_ptr) && $stable(dst_ptr) && $stable(cnt_out) && $stable(flags_out)));

  a_r10_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
endmodule

bind blkcopy_engine blkcopy_checker #(.AW(AW), .CW(CW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dir_q(dir_q),
  .mem_req(mem_req), .mem_we(mem_we), .busy(busy), .done(done),
  .src_ptr(src_ptr), .dst_ptr(dst_ptr), .cnt_out(cnt_out),
  .flags_out(flags_out), .tst_total(tst_total)
);

// File: tb/sim_blkcopy_engine.sv
`timescale 1ns/1ps
module sim_blkcopy_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dir_down = 1'b0;
  logic [15:0] src_init = '0, dst_init = '0, cnt_init = '0;
  logic [7:0]  flags_in = '0;
  logic        mem_req, mem_we, busy, done;
  logic [15:0] mem_addr, src_ptr, dst_ptr, cnt_out;
  logic [7:0]  mem_wdata, flags_out;
  logic [7:0]  mem_rdata = '0;
  logic [19:0] mcyc_total;
  logic [23:0] tst_total;

  always #5 clk = ~clk;

  blkcopy_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_down(dir_down),
    .src_init(src_init), .dst_init(dst_init), .cnt_init(cnt_init),
    .flags_in(flags_in), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
    .cnt_out(cnt_out), .flags_out(flags_out),
    .mcyc_total(mcyc_total), .tst_total(tst_total)
  );

  logic [7:0] mem     [65536];
  logic [7:0] ref_mem [65536];
  int wr_count = 0;
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_count <= wr_count + 1;
      end else begin
        mem_rdata <= mem[mem_addr];
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  function automatic int steps(input logic [15:0] c);
    return (c == 16'd0) ? 65536 : int'(c);
  endfunction

  task automatic ref_copy(input logic [15:0] s, input logic [15:0] d,
                          input int n, input bit dn);
    logic [15:0] ps = s, pd = d;
    for (int i = 0; i < n; i++) begin
      ref_mem[pd] = ref_mem[ps];
      ps = dn ? ps - 16'd1 : ps + 16'd1;
      pd = dn ? pd - 16'd1 : pd + 16'd1;
    end
  endtask

  task automatic run_copy(input logic [15:0] s, input logic [15:0] d,
                          input logic [15:0] c, input bit dn,
                          input logic [7:0] f, input bit poke);
    int n = steps(c);
    int wbase, cyc, bad;
    logic [15:0] es, ed, hs, hd, hc;
    logic [7:0] hf;
    for (int i = 0; i < 65536; i++) ref_mem[i] = mem[i];
    ref_copy(s, d, n, dn);
    es = dn ? s - 16'(n) : s + 16'(n);
    ed = dn ? d - 16'(n) : d + 16'(n);
    wbase = wr_count;
    @(negedge clk);
    src_init = s; dst_init = d; cnt_init = c; dir_down = dn; flags_in = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3", "busy after start", 32'(busy), 32'd1);
    if (poke) begin
      // R7: a second start with other operands, mid-copy
      src_init = ~s; dst_init = ~d; cnt_init = 16'd3; dir_down = ~dn; flags_in = ~f;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 140000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R8", "done seen", 32'(done), 32'd1);
    chk(poke ? "R7" : "R2", "src end", 32'(src_ptr), 32'(es));
    chk(poke ? "R7" : "R2", "dst end", 32'(dst_ptr), 32'(ed));
    chk("R3", "count end", 32'(cnt_out), 32'd0);
    chk("R5", "flags end", 32'(flags_out), 32'(f & 8'hE9));
    chk("R6", "machine cycles", 32'(mcyc_total), 32'(5 * (n - 1) + 4));
    chk("R6", "states", 32'(tst_total), 32'(21 * (n - 1) + 16));
    chk(c == 0 ? "R4" : "R1", "write count", 32'(wr_count - wbase), 32'(n));
    bad = 0;
    for (int i = 0; i < 65536; i++) if (mem[i] !== ref_mem[i]) bad++;
    chk("R1", "memory mismatches", 32'(bad), 32'd0);
    hs = src_ptr; hd = dst_ptr; hc = cnt_out; hf = flags_out;
    @(negedge clk);
    chk("R8", "done width", 32'(done), 32'd0);
    chk("R8", "hold", {hs ^ src_ptr, hd ^ dst_ptr}, 32'd0);
    chk("R8", "hold cnt/flags", {8'd0, hc ^ cnt_out, hf ^ flags_out}, 32'd0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 65536; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "busy", 32'(busy), 32'd0);
    chk("R9", "done", 32'(done), 32'd0);
    chk("R9", "mem_req", 32'(mem_req), 32'd0);
    chk("R9", "regs", {src_ptr, dst_ptr}, 32'd0);
    chk("R9", "cnt/flags", {8'd0, cnt_out, flags_out}, 32'd0);
    chk("R9", "totals", 32'(mcyc_total) | 32'(tst_total), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "idle no request", 32'(mem_req), 32'd0);

    run_copy(16'h1000, 16'h3000, 16'd1, 1'b0, 8'hFF, 1'b0);   // R6 final only
    run_copy(16'hFFFE, 16'h4000, 16'd4, 1'b0, 8'h16, 1'b0);   // R4 wrap up
    run_copy(16'h0002, 16'h0001, 16'd5, 1'b1, 8'hC1, 1'b0);   // R2 down, wrap
    run_copy(16'h2000, 16'h2001, 16'd8, 1'b0, 8'h55, 1'b0);   // R1 overlap
    run_copy(16'h5000, 16'h6000, 16'd10, 1'b0, 8'hAA, 1'b1);  // R7 poke
    for (int k = 0; k < 16; k++) begin
      run_copy(16'($urandom), 16'($urandom), 16'($urandom_range(1, 48)),
               1'($urandom), 8'($urandom), 1'b0);
    end
    run_copy(16'h8000, 16'h0100, 16'd0, 1'b0, 8'h3C, 1'b0);   // R4 full pass
    summary();
  end
endmodule